// File: doc/BRIEF.md
# Random Dummy Current Load Controller

This block makes the supply current of a chip vary in a way that cannot be predicted from the work the chip is doing. Each clock it takes one bit from a serial random source (in silicon an amplified noise voltage sliced by a comparator; here a plain input) and pushes it into a shift register. The low field of that register is turned into a thermometer code, and each line of the code switches one dummy load cell on. An enabled load cell flips its output every clock, so it charges and discharges the buffer it drives, and the number of cells that switch in a cycle follows the random word.

A block enable lets the surrounding logic turn the dummy load off. While it is low, no load cell is enabled and the random word is frozen, so switching resumes from the same word when the enable returns.

Top module: `rnd_load_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the random word and every load cell state to zero; in the first cycle after reset no load line is enabled even with the block enabled.
- R2: With the block enabled, each rising clock edge shifts the random word up by one place and puts the sampled random bit in bit 0.
- R3: Load enable line i is high exactly when the block is enabled and i is below the unsigned value of the random word's bits 2:0 (value k enables lines 0 to k-1).
- R4: Between zero and seven load lines are active at once, and the top line (line 7) is never enabled.
- R5: Each load cell whose enable line is high at a rising edge inverts its state on that edge.
- R6: Each load cell whose enable line is low at a rising edge keeps its state.
- R7: While the block enable is low, all eight load enable lines are low and no load cell changes state.
- R8: While the block enable is low, the random word holds its value and the random input is ignored.
- R9: Random word bits 7:3 have no effect on the load enable lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Block enable |
| rnd_bit | input | 1 | Sampled random bit from the noise comparator |
| load_en | output | 8 | Enable of each dummy buffer, thermometer coded |
| load_q | output | 8 | State of each dummy load cell, drives its buffer |

## Verification
Directed bit patterns set the low field to each value from zero up to seven, which tells a correct thermometer apart from a binary or one-hot decode and shows the top line staying idle at the largest value. A pattern with ones in the upper bits and zeros in the low field separates a decoder that reads the correct field from one that reads the wrong bits. Enable gaps with the random input still toggling show whether the word and the load cells freeze, and a long stretch of seeded random bits with random enable drops compares both outputs every cycle against a bench model of shift, decode and toggle.

// File: rtl/rnd_load_pkg.sv
package rnd_load_pkg;
   // Thermometer code of a count: the lowest cnt lines set.
   function automatic logic [63:0] thermo64(input int unsigned cnt);
      logic [63:0] v;
      v = '0;
      for (int i = 0; i < 64; i++) begin
         v[i] = (i < cnt);
      end
      return v;
   endfunction
endpackage

// File: rtl/rnd_word_shifter.sv
module rnd_word_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("rnd_word_shifter: WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (shift_en) begin
         word <= {word[WORD_W-2:0], bit_in};
      end
   end
endmodule

// File: rtl/thermo_decoder.sv
module thermo_decoder #(
   parameter int SEL_W   = 3,
   parameter int N_LINES = 8
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic               gate,
   output logic [N_LINES-1:0] lines
);
   localparam int MAX_CNT = (1 << SEL_W) - 1;

   generate
      if (N_LINES < MAX_CNT) begin : g_bad_lines
         $error("thermo_decoder: N_LINES too small for SEL_W");
      end
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         if (i >= MAX_CNT) begin : g_unused
            assign lines[i] = 1'b0;
         end else begin : g_used
            assign lines[i] = gate && (int'(sel) > i);
         end
      end
   endgenerate
endmodule

// File: rtl/load_cell_array.sv
module load_cell_array #(
   parameter int N_CELLS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CELLS-1:0] cell_en,
   output logic [N_CELLS-1:0] cell_q
);
   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cell_q[i] <= 1'b0;
            end else if (cell_en[i]) begin
               cell_q[i] <= ~cell_q[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rnd_load_ctrl.sv
module rnd_load_ctrl #(
   parameter int WORD_W  = 8,
   parameter int SEL_W   = 3,
   parameter int N_LOADS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               rnd_bit,
   output logic [N_LOADS-1:0] load_en,
   output logic [N_LOADS-1:0] load_q
);
   localparam int MAX_ACTIVE = (1 << SEL_W) - 1;

   generate
      if (SEL_W > WORD_W) begin : g_bad_sel
         $error("rnd_load_ctrl: SEL_W exceeds WORD_W");
      end
      if (N_LOADS < MAX_ACTIVE) begin : g_bad_loads
         $error("rnd_load_ctrl: N_LOADS below decoder range");
      end
   endgenerate

   logic [WORD_W-1:0] word;

   rnd_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (en),
      .bit_in   (rnd_bit),
      .word     (word)
   );

   thermo_decoder #(.SEL_W(SEL_W), .N_LINES(N_LOADS)) u_dec (
      .sel   (word[SEL_W-1:0]),
      .gate  (en),
      .lines (load_en)
   );

   load_cell_array #(.N_CELLS(N_LOADS)) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .cell_en (load_en),
      .cell_q  (load_q)
   );
endmodule

// File: rtl/rnd_load_ctrl_chk.sv
module rnd_load_ctrl_chk #(
   parameter int N_LOADS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic [N_LOADS-1:0] load_en,
   input logic [N_LOADS-1:0] load_q
);
   logic hist_ok;
   always_ff @(posedge clk) hist_ok <= rst_n;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (load_q == '0)); // R1

   AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      ((load_en & (load_en + 1'b1)) == '0)); // R3

   AST_TOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en[N_LOADS-1]); // R4

   AST_TOGGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      ##1 ((load_q ^ $past(load_q)) == $past(load_en))); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      !en |=> $stable(load_q)); // R7
endmodule

bind rnd_load_ctrl rnd_load_ctrl_chk #(.N_LOADS(N_LOADS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .load_en (load_en),
   .load_q  (load_q)
);

// File: tb/test_rnd_load_ctrl.sv
module test_rnd_load_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       rnd_bit = 1'b0;
   logic [7:0] load_en;
   logic [7:0] load_q;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] m_word = '0;
   logic [7:0] m_q = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rnd_load_ctrl i_rnd_load_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .rnd_bit(rnd_bit),
      .load_en(load_en), .load_q(load_q)
   );

   function automatic logic [7:0] exp_en(input logic e, input logic [7:0] w);
      logic [7:0] v = '0;
      for (int i = 0; i < 8; i++) v[i] = e && (i < int'(w[2:0]));
      return v;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Drive after falling edge, check, then advance the model over the next rising edge.
   task automatic step(input logic r, input logic e, input logic b, input string tag);
      logic [7:0] ee;
      rst_n = r; en = e; rnd_bit = b;
      #1;
      ee = exp_en(e, m_word);
      check({tag, " load_en"}, load_en, ee);
      check({tag, " load_q"}, load_q, m_q);
      if (!r) begin
         m_word = '0; m_q = '0;
      end else if (e) begin
         m_q = m_q ^ ee;
         m_word = {m_word[6:0], b};
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      m_word = '0; m_q = '0;
      // R1: reset state, enabled first cycle drives nothing
      step(1, 1, 1, "R1");
      // R2 R3: fill low field 1,0,1 -> values 1,2,5 ... walk through each count
      step(1, 1, 0, "R2 R3");
      step(1, 1, 1, "R2 R3");
      step(1, 1, 1, "R2 R3");
      step(1, 1, 1, "R2 R3");
      // R4: low field now 111, seven lines, top idle
      step(1, 1, 0, "R4");
      n_cmp++;
      if (load_en[7] !== 1'b0) begin n_bad++; $display("FAIL R4: actual %b expected 0", load_en[7]); end
      step(1, 1, 0, "R4 R5");
      // R9: upper bits ones, low field cleared
      step(1, 1, 0, "R9");
      step(1, 1, 0, "R9");
      check("R9 field zero load_en", load_en, 8'h00);
      // R7 R8: disable with toggling random input
      for (int i = 0; i < 6; i++) step(1, 0, i[0], "R7 R8");
      check("R7 idle load_en", load_en, 8'h00);
      step(1, 1, 1, "R8 resume");
      step(1, 1, 1, "R8 resume");
      step(1, 1, 1, "R5 R6");
      // R1: reset mid-run while enabled
      step(0, 1, 1, "R1");
      step(1, 1, 1, "R1 after");
      check("R1 cells cleared", load_q, 8'h00);
      // R5 R6 R2: seeded random run with random enable drops
      for (int i = 0; i < 3000; i++) begin
         logic e, b, r;
         e = ($urandom_range(0, 9) != 0);
         b = $urandom_range(0, 1) == 1;
         r = ($urandom_range(0, 499) != 0);
         step(r, e, b, "R2 R3 R5 R6 R7");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule